// File: doc/BRIEF.md
# Register-Mapped SPI Master Engine

This block is an SPI master driven through a handful of word registers on a simple synchronous register bus. Software pushes one word of up to 32 bits into a four-entry transmit queue. It then writes the command register with the bit count, the clock mode, the chip-select choice and the start bit. The engine pops the word and shifts it out most-significant bit first. While it does so it captures the returned bits and pushes them, right-aligned to the programmed length, into a four-entry receive queue. When the last bit is done it raises a sticky ready flag.

Register reads return data combinationally in the cycle the read strobe is high. A read of the receive port pops the queue on the following clock edge. Status flags for queue misuse are sticky and are cleared by writing ones. The serial clock is the system clock divided by the even parameter `CLK_DIV`.

Top module: `spi_master_engine`

## Requirements
- R1: After reset all four chip-select outputs are high, `sclk` and `mosi` are low, the transfer-status register reads 0 and the FIFO-status register (offset 0x014) reads 0x005, meaning both queues are empty.
- R2: A start request shifts N = (command bits 4:0) + 1 bits. Bits leave MSB-first from the right-aligned transmit word. The N bits captured from `miso` appear right-aligned and zero-extended in the next word read from the receive port (offset 0x188). The transmit port is at offset 0x108.
- R3: Command bits 29:28 give the clock mode as {polarity, phase}. `sclk` idles at the polarity level. With phase 0, data is sampled on the leading edge. With phase 1, it is sampled on the trailing edge. One serial-clock period lasts `CLK_DIV` system clocks.
- R4: Bit 30 of the transfer-status register (offset 0x010) becomes 1 when a transfer completes. It stays 1 until software writes a 1 to that bit.
- R5: A command write with bit 31 (start) set begins a transfer only when bit 30 (master) is also set and no transfer is running. Otherwise nothing is shifted and the queues are untouched. The start bit always reads back as 0.
- R6: With bit 21 clear, the chip select picked by command bits 27:26 is driven low exactly while a transfer runs. With bit 21 set, that line follows bit 20 and the other lines stay high. At most one line is ever low.
- R7: A write to the transmit port while it holds four words is dropped. It sets FIFO-status bit 7 (transmit overflow) and bit 8 (error). Bit 3 reports transmit full. Writing 1 to a status bit clears it.
- R8: A read of an empty receive port returns 0 and sets bit 4 (receive underrun) and bit 8.
- R9: A transfer that ends while the receive queue holds four words drops its word and sets bit 5 (receive overflow) and bit 8. Bit 1 reports receive full.
- R10: A start with transmit enabled while the transmit queue is empty shifts zeros and sets bit 6 (transmit underrun) and bit 8.
- R11: Command bit 11 enables transmit: when it is clear, `mosi` stays low and the transmit queue is not popped. Bit 12 enables receive: when it is clear, nothing is pushed into the receive queue.
- R12: With command bit 15 set and N a multiple of 8, the byte order is reversed in both directions. The least significant byte of the transmit word goes out first. The first received byte lands in the least significant byte of the receive word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe (pops the receive port) |
| busAddr | input | 9 | Register byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of the read strobe |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 4 | Active-low chip selects |

## Verification
The bench drives transfers against a bus-side slave model. The model samples and shifts on its own idea of each mode. This lets a wrong edge choice, a missing first-edge skip for phase 1, or a wrong bit order show up as a corrupted word on one side or the other.

The four modes are run at lengths of 8, 13, 24 and 32 bits, with asymmetric data words. The 13-bit case separates right alignment from left alignment. The 24-bit byte-reversed case separates byte order from bit order.

Queue misuse is driven to each boundary: a fifth push, a fifth receive, a read of an empty port, and a start with an empty transmit queue. A start while busy and a start with the master bit clear are both checked against the slave's edge count and the queue levels.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam logic [8:0] ADDR_CMD    = 9'h000;
  localparam logic [8:0] ADDR_XSTAT  = 9'h010;
  localparam logic [8:0] ADDR_FSTAT  = 9'h014;
  localparam logic [8:0] ADDR_TXPORT = 9'h108;
  localparam logic [8:0] ADDR_RXPORT = 9'h188;

  localparam int B_GO     = 31;
  localparam int B_MASTER = 30;
  localparam int B_CPOL   = 29;
  localparam int B_CPHA   = 28;
  localparam int B_CSSW   = 21;
  localparam int B_CSVAL  = 20;
  localparam int B_LSBY   = 15;
  localparam int B_RXEN   = 12;
  localparam int B_TXEN   = 11;
  localparam int B_RDY    = 30;

  // writable command bits: everything but the start bit
  localparam logic [31:0] CMD_KEEP = 32'h7C30_981F;

  typedef struct packed {
    logic [4:0] lenM1;
    logic       lsbFirst;
    logic       txEn;
    logic       rxEn;
  } xferCfg_t;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic load;
    logic shift;
    logic sample;
    logic finish;
  } dpStrobe_t;

  // reverse the byte order of the low nBits bits; identity when nBits is not whole bytes
  function automatic logic [31:0] swapBytes(input logic [31:0] w, input logic [5:0] nBits);
    logic [31:0] r;
    int nb;
    if (nBits[2:0] != 3'd0) return w;
    nb = int'(nBits >> 3);
    r = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < nb) r[8*(nb-1-i) +: 8] = w[8*i +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  assign doPush = push && (count != CW'(DEPTH));
  assign doPop  = pop && (count != '0);
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + AW'(1);
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + AW'(1);
      case ({doPush, doPop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R9
endmodule

// File: rtl/spi_datapath.sv
module spi_datapath
  import spi_eng_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     stb,
  input  xferCfg_t      cfg,
  input  logic [31:0]   pushData,
  input  logic          miso,
  output logic          mosi,
  output logic [31:0]   rxHead,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount
);
  logic [31:0] txOut, txWord, txAligned, rxWord;
  logic [31:0] txSh, rxSh;
  logic [5:0]  nBits;

  assign nBits     = {1'b0, cfg.lenM1} + 6'd1;
  assign txWord    = (cfg.txEn && txCount != '0) ? txOut : '0;
  assign txAligned = (cfg.lsbFirst ? swapBytes(txWord, nBits) : txWord) << (6'd32 - nBits);
  assign rxWord    = cfg.lsbFirst ? swapBytes(rxSh, nBits) : rxSh;
  assign mosi      = cfg.txEn & txSh[31];

  spi_fifo #(.W(32), .DEPTH(DEPTH)) uTxq (
    .clk(clk), .rstN(rstN), .push(stb.txPush), .pop(stb.load && cfg.txEn),
    .din(pushData), .dout(txOut), .count(txCount));

  spi_fifo #(.W(32), .DEPTH(DEPTH)) uRxq (
    .clk(clk), .rstN(rstN), .push(stb.finish && cfg.rxEn), .pop(stb.rxPop),
    .din(rxWord), .dout(rxHead), .count(rxCount));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh <= '0;
      rxSh <= '0;
    end else if (stb.load) begin
      txSh <= txAligned;
      rxSh <= '0;
    end else begin
      if (stb.shift)  txSh <= {txSh[30:0], 1'b0};
      if (stb.sample) rxSh <= {rxSh[30:0], miso};
    end
  end

  AST_RX_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |-> ((rxSh >> nBits) == 32'd0)); // R2
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_eng_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int DEPTH   = 4,
  localparam int HALF   = (CLK_DIV / 2 < 1) ? 1 : CLK_DIV / 2,
  localparam int DCW    = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWe,
  input  logic          busRe,
  input  logic [8:0]    busAddr,
  input  logic [31:0]   busWdata,
  output logic [31:0]   busRdata,
  input  logic [CW-1:0] txCount,
  input  logic [CW-1:0] rxCount,
  input  logic [31:0]   rxHead,
  output dpStrobe_t     stb,
  output xferCfg_t      cfg,
  output logic          sclk,
  output logic [3:0]    csN
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;
  state_t          state;
  logic [31:0]     cmdReg;
  xferCfg_t        cfgQ, wrCfg;
  logic            cpolQ, cphaQ, sclkQ, readyQ;
  logic [1:0]      csSelQ;
  logic [DCW-1:0]  divCnt;
  logic [5:0]      edgeCnt;
  logic            txOvf, txUnr, rxOvf, rxUnr, anyErr;
  logic            wrCmd, goReq, tick, leading, lastEdge, txFull, rxFull;
  logic            clrWr;

  assign wrCmd    = busWe && busAddr == ADDR_CMD;
  assign goReq    = wrCmd && busWdata[B_GO] && busWdata[B_MASTER] && state == S_IDLE;
  assign wrCfg    = '{lenM1: busWdata[4:0], lsbFirst: busWdata[B_LSBY],
                      txEn: busWdata[B_TXEN], rxEn: busWdata[B_RXEN]};
  assign cfg      = goReq ? wrCfg : cfgQ;
  assign tick     = state == S_RUN && divCnt == DCW'(HALF - 1);
  assign leading  = ~edgeCnt[0];
  assign lastEdge = edgeCnt == {cfgQ.lenM1, 1'b1};
  assign txFull   = txCount == CW'(DEPTH);
  assign rxFull   = rxCount == CW'(DEPTH);
  assign anyErr   = txOvf | txUnr | rxOvf | rxUnr;
  assign clrWr    = busWe && busAddr == ADDR_FSTAT;

  always_comb begin
    stb.txPush = busWe && busAddr == ADDR_TXPORT;
    stb.rxPop  = busRe && busAddr == ADDR_RXPORT;
    stb.load   = goReq;
    stb.sample = tick && (leading ^ cphaQ);
    stb.shift  = tick && (leading ? (cphaQ && edgeCnt != 6'd0) : !cphaQ);
    stb.finish = state == S_FIN;
  end

  assign sclk = (state == S_IDLE) ? cmdReg[B_CPOL] : sclkQ;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      if (cmdReg[B_CSSW])
        csN[i] = (2'(i) == cmdReg[27:26]) ? cmdReg[B_CSVAL] : 1'b1;
      else
        csN[i] = !(state != S_IDLE && 2'(i) == csSelQ);
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_CMD:    busRdata = cmdReg;
      ADDR_XSTAT:  busRdata = {1'b0, readyQ, 30'd0};
      ADDR_FSTAT:  busRdata = {23'd0, anyErr, txOvf, txUnr, rxOvf, rxUnr,
                               txFull, txCount == '0, rxFull, rxCount == '0};
      ADDR_RXPORT: busRdata = (rxCount != '0) ? rxHead : 32'd0;
      default:     busRdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; cmdReg <= '0; cfgQ <= '0; cpolQ <= 1'b0; cphaQ <= 1'b0;
      csSelQ <= '0; divCnt <= '0; edgeCnt <= '0; sclkQ <= 1'b0; readyQ <= 1'b0;
      txOvf <= 1'b0; txUnr <= 1'b0; rxOvf <= 1'b0; rxUnr <= 1'b0;
    end else begin
      if (wrCmd) cmdReg <= busWdata & CMD_KEEP;
      case (state)
        S_IDLE: if (goReq) begin
          state   <= S_RUN;
          cfgQ    <= wrCfg;
          cpolQ   <= busWdata[B_CPOL];
          cphaQ   <= busWdata[B_CPHA];
          csSelQ  <= busWdata[27:26];
          sclkQ   <= busWdata[B_CPOL];
          divCnt  <= '0;
          edgeCnt <= '0;
        end
        S_RUN: if (tick) begin
          divCnt  <= '0;
          sclkQ   <= ~sclkQ;
          edgeCnt <= edgeCnt + 6'd1;
          if (lastEdge) state <= S_FIN;
        end else begin
          divCnt <= divCnt + DCW'(1);
        end
        default: state <= S_IDLE;
      endcase

      if (stb.finish) readyQ <= 1'b1;
      else if (busWe && busAddr == ADDR_XSTAT && busWdata[B_RDY]) readyQ <= 1'b0;

      if (stb.txPush && txFull) txOvf <= 1'b1;
      else if (clrWr && busWdata[7]) txOvf <= 1'b0;
      if (goReq && wrCfg.txEn && txCount == '0) txUnr <= 1'b1;
      else if (clrWr && busWdata[6]) txUnr <= 1'b0;
      if (stb.finish && cfgQ.rxEn && rxFull) rxOvf <= 1'b1;
      else if (clrWr && busWdata[5]) rxOvf <= 1'b0;
      if (stb.rxPop && rxCount == '0) rxUnr <= 1'b1;
      else if (clrWr && busWdata[4]) rxUnr <= 1'b0;
    end
  end

  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= 1); // R6
  AST_SCLK_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    state == S_FIN |-> sclkQ == cpolQ); // R3
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    readyQ && !(busWe && busAddr == ADDR_XSTAT && busWdata[B_RDY]) |=> readyQ); // R4
  AST_GO_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    state != S_IDLE |=> $stable(cfgQ)); // R5
  AST_TX_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txOvf) |-> $past(stb.txPush && txFull)); // R7
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_eng_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic        busRe,
  input  logic [8:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  csN
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  dpStrobe_t     stb;
  xferCfg_t      cfg;
  logic [CW-1:0] txCount, rxCount;
  logic [31:0]   rxHead;

  spi_ctrl #(.CLK_DIV(CLK_DIV), .DEPTH(FIFO_DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .txCount(txCount), .rxCount(rxCount),
    .rxHead(rxHead), .stb(stb), .cfg(cfg), .sclk(sclk), .csN(csN));

  spi_datapath #(.DEPTH(FIFO_DEPTH)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .cfg(cfg), .pushData(busWdata),
    .miso(miso), .mosi(mosi), .rxHead(rxHead), .txCount(txCount), .rxCount(rxCount));
endmodule

// File: tb/sim_spi_master_engine.sv
module sim_spi_master_engine;
  localparam logic [8:0] A_CMD = 9'h000, A_XST = 9'h010, A_FST = 9'h014,
                         A_TX = 9'h108, A_RX = 9'h188;
  localparam logic [31:0] GO = 32'h8000_0000, MST = 32'h4000_0000, RDY = 32'h4000_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0, we = 1'b0, re = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sclk, mosi, miso;
  logic [3:0]  csN;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  logic [31:0] slvOut = '0, slvIn = '0;
  int          slvEdges = 0;
  logic        slvCpol = 1'b0, slvCpha = 1'b0;
  assign miso = slvOut[31];

  spi_master_engine u0 (
    .clk(clk), .rstN(rstN), .busWe(we), .busRe(re), .busAddr(addr),
    .busWdata(wdata), .busRdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN));

  // bench slave: samples and shifts from its own view of the mode
  always @(sclk) begin
    if (csN != 4'hF) begin
      if ((sclk != slvCpol) ^ slvCpha) slvIn = {slvIn[30:0], mosi};
      else if (!(slvCpha && slvEdges == 0)) slvOut = slvOut << 1;
      slvEdges++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  function automatic logic [31:0] mkCmd(input logic [1:0] mode, input logic [4:0] lenM1,
      input logic [1:0] cs, input bit txEn, input bit rxEn, input bit lsb);
    return MST | (32'(mode) << 28) | (32'(cs) << 26) | (32'(lsb) << 15) |
           (32'(rxEn) << 12) | (32'(txEn) << 11) | 32'(lenM1);
  endfunction

  task automatic waitReady(input string req);
    logic [31:0] v;
    v = '0;
    for (int k = 0; k < 3000 && !v[30]; k++) rd(A_XST, v);
    check(req, v, RDY);
  endtask

  // full transfer with slave word; checks idle clock, slave capture, edge count and ready
  task automatic runXfer(input logic [1:0] mode, input logic [4:0] lenM1, input logic [1:0] cs,
      input bit txEn, input bit rxEn, input bit lsb, input logic [31:0] slvWord,
      input logic [31:0] expIn, input string req);
    logic [31:0] cmd, v;
    int nb;
    nb = int'(lenM1) + 1;
    slvCpol = mode[1]; slvCpha = mode[0];
    slvOut = slvWord << (32 - nb); slvIn = '0; slvEdges = 0;
    cmd = mkCmd(mode, lenM1, cs, txEn, rxEn, lsb);
    wr(A_CMD, cmd);
    check({req, " R3 idle sclk"}, 32'(sclk), 32'(mode[1]));
    wr(A_CMD, cmd | GO);
    waitReady({req, " R4 ready set"});
    check({req, " slave captured"}, slvIn, expIn);
    check({req, " R2 edge count"}, 32'(slvEdges), 32'(2 * nb));
    wr(A_XST, RDY);
    rd(A_XST, v);
    check({req, " R4 ready cleared"}, v, 32'd0);
  endtask

  task automatic tReset();
    logic [31:0] v;
    check("R1 csN", 32'(csN), 32'hF);
    check("R1 sclk", 32'(sclk), 32'd0);
    check("R1 mosi", 32'(mosi), 32'd0);
    rd(A_XST, v); check("R1 xfer status", v, 32'd0);
    rd(A_FST, v); check("R1 fifo status", v, 32'h005);
  endtask

  task automatic tBasic();
    logic [31:0] v;
    wr(A_TX, 32'hA5C3_1E77);
    runXfer(2'd0, 5'd31, 2'd1, 1, 1, 0, 32'h3C5A_9611, 32'hA5C3_1E77, "R2 mode0 32b");
    rd(A_RX, v); check("R2 rx word 32b", v, 32'h3C5A_9611);
    rd(A_CMD, v); check("R5 start reads 0", v[31] ? 32'd1 : 32'd0, 32'd0);
  endtask

  task automatic tModes();
    logic [31:0] v;
    wr(A_TX, 32'h96);
    runXfer(2'd1, 5'd7, 2'd0, 1, 1, 0, 32'h3C, 32'h96, "R3 mode1 8b");
    rd(A_RX, v); check("R3 mode1 rx", v, 32'h3C);
    wr(A_TX, 32'h1ABC);
    runXfer(2'd2, 5'd12, 2'd2, 1, 1, 0, 32'h0ACE, 32'h1ABC, "R3 mode2 13b");
    rd(A_RX, v); check("R2 R3 mode2 rx aligned", v, 32'h0ACE);
    wr(A_TX, 32'hDEAD_BEEF);
    runXfer(2'd3, 5'd31, 2'd3, 1, 1, 0, 32'h0123_4567, 32'hDEAD_BEEF, "R3 mode3 32b");
    rd(A_RX, v); check("R3 mode3 rx", v, 32'h0123_4567);
  endtask

  task automatic tChipSelect();
    logic [31:0] cmd, v;
    cmd = mkCmd(2'd0, 5'd31, 2'd2, 1, 1, 0);
    wr(A_TX, 32'h0F0F_0F0F);
    slvCpol = 1'b0; slvCpha = 1'b0; slvOut = '0; slvIn = '0; slvEdges = 0;
    wr(A_CMD, cmd);
    wr(A_CMD, cmd | GO);
    repeat (10) @(negedge clk);
    check("R6 hw cs active", 32'(csN), 32'hB);
    waitReady("R6 ready");
    check("R6 hw cs released", 32'(csN), 32'hF);
    wr(A_XST, RDY);
    rd(A_RX, v);
    wr(A_CMD, MST | (32'd1 << 21) | (32'd1 << 26));
    check("R6 sw cs low", 32'(csN), 32'hD);
    wr(A_CMD, MST | (32'd1 << 21) | (32'd1 << 20) | (32'd1 << 26));
    check("R6 sw cs high", 32'(csN), 32'hF);
    wr(A_CMD, MST);
  endtask

  task automatic tGoIgnored();
    logic [31:0] v;
    wr(A_TX, 32'hCAFE_F00D);
    wr(A_TX, 32'h0000_00B7);
    slvCpol = 1'b0; slvCpha = 1'b0; slvOut = 32'h8000_0001; slvIn = '0; slvEdges = 0;
    wr(A_CMD, mkCmd(2'd0, 5'd31, 2'd0, 1, 1, 0));
    wr(A_CMD, mkCmd(2'd0, 5'd31, 2'd0, 1, 1, 0) | GO);
    wr(A_CMD, mkCmd(2'd0, 5'd7, 2'd0, 1, 1, 0) | GO);
    waitReady("R5 ready");
    check("R5 busy start ignored: slave word", slvIn, 32'hCAFE_F00D);
    check("R5 busy start ignored: edges", 32'(slvEdges), 32'd64);
    wr(A_XST, RDY);
    rd(A_FST, v); check("R5 one rx word, tx left", v, 32'h000);
    rd(A_RX, v); check("R5 rx word", v, 32'h8000_0001);
    slvEdges = 0;
    wr(A_CMD, (mkCmd(2'd0, 5'd7, 2'd0, 1, 1, 0) & ~MST) | GO);
    repeat (60) @(negedge clk);
    check("R5 no master: no edges", 32'(slvEdges), 32'd0);
    rd(A_XST, v); check("R5 no master: no ready", v, 32'd0);
    rd(A_FST, v); check("R5 no master: tx kept", v, 32'h001);
    runXfer(2'd0, 5'd7, 2'd0, 1, 0, 0, 32'h00, 32'hB7, "R5 second word intact");
  endtask

  task automatic tTxOverflow();
    logic [31:0] v;
    for (int k = 0; k < 5; k++) wr(A_TX, 32'h10 + 32'(k));
    rd(A_FST, v); check("R7 tx overflow flags", v, 32'h189);
    wr(A_FST, 32'h180);
    rd(A_FST, v); check("R7 overflow cleared", v, 32'h009);
    for (int k = 0; k < 4; k++)
      runXfer(2'd0, 5'd7, 2'd0, 1, 0, 0, 32'hFF, 32'h10 + 32'(k), "R7 R11 drain");
    rd(A_FST, v); check("R11 rx disabled: nothing pushed", v, 32'h005);
  endtask

  task automatic tRxUnderrun();
    logic [31:0] v;
    rd(A_RX, v); check("R8 empty read zero", v, 32'd0);
    rd(A_FST, v); check("R8 underrun flags", v, 32'h115);
    wr(A_FST, 32'h110);
    rd(A_FST, v); check("R8 cleared", v, 32'h005);
  endtask

  task automatic tRxOverflow();
    logic [31:0] v;
    for (int k = 0; k < 5; k++)
      runXfer(2'd0, 5'd7, 2'd0, 0, 1, 0, 32'h11 * 32'(k + 1), 32'h0, "R9 R11 tx off");
    rd(A_FST, v); check("R9 rx overflow flags", v, 32'h126);
    for (int k = 0; k < 4; k++) begin
      rd(A_RX, v); check("R9 kept words", v, 32'h11 * 32'(k + 1));
    end
    wr(A_FST, 32'h120);
    rd(A_FST, v); check("R9 cleared", v, 32'h005);
  endtask

  task automatic tTxUnderrun();
    logic [31:0] v;
    runXfer(2'd0, 5'd15, 2'd0, 1, 1, 0, 32'hBEEF, 32'h0, "R10 zeros shifted");
    rd(A_FST, v); check("R10 underrun flags", v, 32'h144);
    rd(A_RX, v); check("R10 rx still captured", v, 32'hBEEF);
    wr(A_FST, 32'h140);
    rd(A_FST, v); check("R10 cleared", v, 32'h005);
  endtask

  task automatic tTxDisabled();
    logic [31:0] v;
    wr(A_TX, 32'h5A);
    runXfer(2'd0, 5'd7, 2'd0, 0, 0, 0, 32'h00, 32'h0, "R11 mosi low");
    rd(A_FST, v); check("R11 tx not popped", v, 32'h001);
    runXfer(2'd0, 5'd7, 2'd0, 1, 0, 0, 32'h00, 32'h5A, "R11 held word sent");
  endtask

  task automatic tLsbFirst();
    logic [31:0] v;
    wr(A_TX, 32'h00AA_BBCC);
    runXfer(2'd0, 5'd23, 2'd0, 1, 1, 1, 32'h0011_2233, 32'h00CC_BBAA, "R12 byte reversed tx");
    rd(A_RX, v); check("R12 byte reversed rx", v, 32'h0033_2211);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBasic();
    tModes();
    tChipSelect();
    tGoIgnored();
    tTxOverflow();
    tRxUnderrun();
    tRxOverflow();
    tTxUnderrun();
    tTxDisabled();
    tLsbFirst();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule